// File: doc/BRIEF.md
# Superscalar Register Rename Group

This block renames a group of up to four decoded instructions in one clock cycle. Each slot names two architected source registers and one architected destination. Every source is looked up in a register alias table that holds, for each of the eight architected registers, the physical tag of its newest version. Every slot that writes a destination takes a fresh physical tag from a free-tag supply. The free tags are handed out in slot order.

Inside a group, a later slot can read a register that an earlier slot of the same group writes. In that case the table value is stale. The block replaces it with the tag just assigned to the youngest such earlier writer. For each destination, the block also reports the mapping that the destination had before the slot, with the same correction applied, so that the old tag can be released later. At the clock edge the table is updated only by the final writer of each architected register in the group.

If the supply cannot provide a tag for every slot that needs one, the group is held back. In that case no tag is taken and the table keeps its contents. The surrounding pipeline presents the same group again on a later cycle.

Top module: `rename_group`

## Requirements
- R1: After reset, architected register r maps to physical tag r for every r in 0..7.
- R2: A valid slot's source whose register is not written by any earlier valid, destination-writing slot of the group receives the tag currently held in the table for that register.
- R3: A valid slot's source whose register is written by one or more earlier valid, destination-writing slots receives the new tag of the youngest of those slots.
- R4: A slot's sources are never compared with its own destination or with later slots' destinations. A source equal to the slot's own destination gets the mapping from before the slot.
- R5: Slot i, when valid and destination-writing, gets free tag k, where k counts the valid destination-writing slots below i. The free tags are presented as four 5-bit fields, field k at bits [5k+4:5k]. When the group is accepted, the consume count equals the number of such slots.
- R6: Each valid destination-writing slot reports as its prior tag the mapping of its destination just before that slot: either the table value or the new tag of the youngest earlier same-group writer of that register.
- R7: On acceptance, each architected register written in the group holds afterwards the tag of the last slot that wrote it, and at most one table write targets any register.
- R8: A slot that is not valid, or that has no destination, takes no tag and leaves the table untouched.
- R9: When the free count (0..4) is below the number of tags needed, the group stalls: the stall output is 1, accept is 0, the consume count is 0, and the table is unchanged.
- R10: A group with no valid slot is not accepted and consumes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 4 | Per-slot valid, bit i = slot i |
| in_has_dst | input | 4 | Per-slot destination-write flag |
| in_src_a | input | 12 | First source register per slot, 3 bits each, slot i at [3i+2:3i] |
| in_src_b | input | 12 | Second source register per slot |
| in_dst | input | 12 | Destination register per slot |
| fl_avail | input | 3 | Number of free tags that can be taken this cycle (0..4) |
| fl_tags | input | 20 | Next free tags in hand-out order, 5 bits each |
| fl_pop | output | 3 | Number of free tags consumed this cycle |
| out_fire | output | 1 | Group accepted and table updated at this edge |
| out_stall | output | 1 | Group held for lack of free tags |
| out_src_a_tag | output | 20 | Physical tag for each slot's first source |
| out_src_b_tag | output | 20 | Physical tag for each slot's second source |
| out_dst_tag | output | 20 | Newly assigned tag per destination-writing slot |
| out_prev_tag | output | 20 | Prior mapping of each slot's destination |

## Verification
The hardest situation to reach from the ports is a group in which several slots write the same register and other slots read it between those writes. Correctness then depends on choosing the youngest earlier writer, ignoring the slot's own destination, and committing only the final writer, all in one cycle. The bench sweeps all 4096 destination patterns of a four-slot group. For each pattern, sources, valid and destination-write flags, and the free count come from a pseudo-random sequence. This produces dense aliasing, partial groups and frequent stalls. A sequential rename model in the bench predicts every output. Table contents are read back through all-source read-only groups.

// File: rtl/rename_pkg.sv
package rename_pkg;

  localparam int unsigned RN_SLOTS = 4;
  localparam int unsigned RN_AREGS = 8;
  localparam int unsigned RN_PTAGS = 32;

  // Number of set bits in mask strictly below position pos.
  function automatic int unsigned ones_below(input logic [31:0] mask, input int unsigned pos);
    int unsigned n;
    n = 0;
    for (int unsigned k = 0; k < 32; k++) begin
      if (k < pos && mask[k]) n = n + 1;
    end
    return n;
  endfunction

  // Total number of set bits in mask.
  function automatic int unsigned ones_total(input logic [31:0] mask);
    return ones_below(mask, 32);
  endfunction

endpackage

// File: rtl/rename_alias_table.sv
module rename_alias_table #(
  parameter int unsigned SLOTS = 4,
  parameter int unsigned AREGS = 8,
  parameter int unsigned AW    = 3,
  parameter int unsigned TW    = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SLOTS*AW-1:0]   rd_a_idx,
  input  logic [SLOTS*AW-1:0]   rd_b_idx,
  input  logic [SLOTS*AW-1:0]   rd_d_idx,
  output logic [SLOTS*TW-1:0]   rd_a_tag,
  output logic [SLOTS*TW-1:0]   rd_b_tag,
  output logic [SLOTS*TW-1:0]   rd_d_tag,
  input  logic [SLOTS-1:0]      wr_en,
  input  logic [SLOTS*AW-1:0]   wr_idx,
  input  logic [SLOTS*TW-1:0]   wr_tag
);

  logic [TW-1:0]       map_q [AREGS];
  logic [AREGS*TW-1:0] map_flat;
  logic [SLOTS-1:0]    hits  [AREGS];

  // 3*SLOTS read ports: two sources plus destination prior mapping per slot.
  always_comb begin
    for (int unsigned i = 0; i < SLOTS; i++) begin
      rd_a_tag[i*TW +: TW] = map_q[rd_a_idx[i*AW +: AW]];
      rd_b_tag[i*TW +: TW] = map_q[rd_b_idx[i*AW +: AW]];
      rd_d_tag[i*TW +: TW] = map_q[rd_d_idx[i*AW +: AW]];
    end
  end

  always_comb begin
    for (int unsigned r = 0; r < AREGS; r++) begin
      map_flat[r*TW +: TW] = map_q[r];
      for (int unsigned i = 0; i < SLOTS; i++) begin
        hits[r][i] = wr_en[i] && (wr_idx[i*AW +: AW] == AW'(r));
      end
    end
  end

  // SLOTS write ports; the caller guarantees distinct targets.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int unsigned r = 0; r < AREGS; r++) map_q[r] <= TW'(r);
    end else begin
      for (int unsigned i = 0; i < SLOTS; i++) begin
        if (wr_en[i]) map_q[wr_idx[i*AW +: AW]] <= wr_tag[i*TW +: TW];
      end
    end
  end

  generate
    for (genvar r = 0; r < AREGS; r++) begin : g_chk_reg
      AST_ONE_WRITER_PER_REG: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hits[r])); // R7
    end
    for (genvar i = 0; i < SLOTS; i++) begin : g_chk_slot
      AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en[i] |=> map_q[$past(wr_idx[i*AW +: AW])] == $past(wr_tag[i*TW +: TW])); // R7
    end
  endgenerate

  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(|wr_en) |=> $stable(map_flat)); // R9

endmodule

// File: rtl/rename_alloc.sv
module rename_alloc
  import rename_pkg::*;
#(
  parameter int unsigned SLOTS = 4,
  parameter int unsigned TW    = 5,
  parameter int unsigned CW    = 3
) (
  input  logic [SLOTS-1:0]    wr_mask,
  input  logic [SLOTS*TW-1:0] fl_tags,
  input  logic [CW-1:0]       avail,
  output logic [SLOTS*TW-1:0] new_tags,
  output logic [CW-1:0]       need,
  output logic                short_tags
);

  always_comb begin
    for (int unsigned i = 0; i < SLOTS; i++) begin
      int unsigned pick;
      pick = ones_below(32'(wr_mask), i);
      new_tags[i*TW +: TW] = fl_tags[pick*TW +: TW];
    end
    need       = CW'(ones_total(32'(wr_mask)));
    short_tags = need > avail;
  end

endmodule

// File: rtl/rename_bypass.sv
module rename_bypass #(
  parameter int unsigned SLOTS = 4,
  parameter int unsigned AW    = 3,
  parameter int unsigned TW    = 5
) (
  input  logic [SLOTS-1:0]    wr_mask,
  input  logic [SLOTS*AW-1:0] src_a,
  input  logic [SLOTS*AW-1:0] src_b,
  input  logic [SLOTS*AW-1:0] dst,
  input  logic [SLOTS*TW-1:0] tbl_a,
  input  logic [SLOTS*TW-1:0] tbl_b,
  input  logic [SLOTS*TW-1:0] tbl_d,
  input  logic [SLOTS*TW-1:0] new_tags,
  output logic [SLOTS*TW-1:0] fix_a,
  output logic [SLOTS*TW-1:0] fix_b,
  output logic [SLOTS*TW-1:0] fix_prev,
  output logic [SLOTS-1:0]    last_writer
);

  generate
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      logic [TW-1:0] a_t, b_t, p_t;
      logic          last_t;

      // Compare against older slots only; ascending scan leaves the youngest match.
      always_comb begin
        a_t = tbl_a[i*TW +: TW];
        b_t = tbl_b[i*TW +: TW];
        p_t = tbl_d[i*TW +: TW];
        for (int j = 0; j < i; j++) begin
          if (wr_mask[j]) begin
            if (dst[j*AW +: AW] == src_a[i*AW +: AW]) a_t = new_tags[j*TW +: TW];
            if (dst[j*AW +: AW] == src_b[i*AW +: AW]) b_t = new_tags[j*TW +: TW];
            if (dst[j*AW +: AW] == dst[i*AW +: AW])   p_t = new_tags[j*TW +: TW];
          end
        end
      end

      // A writer commits only when no younger slot overwrites the same register.
      always_comb begin
        last_t = wr_mask[i];
        for (int j = i + 1; j < SLOTS; j++) begin
          if (wr_mask[j] && dst[j*AW +: AW] == dst[i*AW +: AW]) last_t = 1'b0;
        end
      end

      assign fix_a[i*TW +: TW]    = a_t;
      assign fix_b[i*TW +: TW]    = b_t;
      assign fix_prev[i*TW +: TW] = p_t;
      assign last_writer[i]       = last_t;
    end
  endgenerate

endmodule

// File: rtl/rename_group.sv
module rename_group
  import rename_pkg::*;
#(
  parameter  int unsigned SLOTS = RN_SLOTS,
  parameter  int unsigned AREGS = RN_AREGS,
  parameter  int unsigned PTAGS = RN_PTAGS,
  localparam int unsigned AW    = $clog2(AREGS),
  localparam int unsigned TW    = $clog2(PTAGS),
  localparam int unsigned CW    = $clog2(SLOTS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SLOTS-1:0]    in_valid,
  input  logic [SLOTS-1:0]    in_has_dst,
  input  logic [SLOTS*AW-1:0] in_src_a,
  input  logic [SLOTS*AW-1:0] in_src_b,
  input  logic [SLOTS*AW-1:0] in_dst,
  input  logic [CW-1:0]       fl_avail,
  input  logic [SLOTS*TW-1:0] fl_tags,
  output logic [CW-1:0]       fl_pop,
  output logic                out_fire,
  output logic                out_stall,
  output logic [SLOTS*TW-1:0] out_src_a_tag,
  output logic [SLOTS*TW-1:0] out_src_b_tag,
  output logic [SLOTS*TW-1:0] out_dst_tag,
  output logic [SLOTS*TW-1:0] out_prev_tag
);

  logic [SLOTS-1:0]    wr_mask;
  logic [SLOTS-1:0]    last_writer;
  logic [SLOTS-1:0]    tbl_wr_en;
  logic [SLOTS*TW-1:0] tbl_a, tbl_b, tbl_d;
  logic [SLOTS*TW-1:0] new_tags;
  logic [CW-1:0]       need;
  logic                short_tags;
  logic                group_live;

  assign wr_mask    = in_valid & in_has_dst;
  assign group_live = |in_valid;

  rename_alias_table #(.SLOTS(SLOTS), .AREGS(AREGS), .AW(AW), .TW(TW)) u_rat (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_a_idx (in_src_a),
    .rd_b_idx (in_src_b),
    .rd_d_idx (in_dst),
    .rd_a_tag (tbl_a),
    .rd_b_tag (tbl_b),
    .rd_d_tag (tbl_d),
    .wr_en    (tbl_wr_en),
    .wr_idx   (in_dst),
    .wr_tag   (new_tags)
  );

  rename_alloc #(.SLOTS(SLOTS), .TW(TW), .CW(CW)) u_alloc (
    .wr_mask    (wr_mask),
    .fl_tags    (fl_tags),
    .avail      (fl_avail),
    .new_tags   (new_tags),
    .need       (need),
    .short_tags (short_tags)
  );

  rename_bypass #(.SLOTS(SLOTS), .AW(AW), .TW(TW)) u_byp (
    .wr_mask     (wr_mask),
    .src_a       (in_src_a),
    .src_b       (in_src_b),
    .dst         (in_dst),
    .tbl_a       (tbl_a),
    .tbl_b       (tbl_b),
    .tbl_d       (tbl_d),
    .new_tags    (new_tags),
    .fix_a       (out_src_a_tag),
    .fix_b       (out_src_b_tag),
    .fix_prev    (out_prev_tag),
    .last_writer (last_writer)
  );

  assign out_stall   = group_live && short_tags;
  assign out_fire    = group_live && !short_tags;
  assign fl_pop      = out_fire ? need : '0;
  assign tbl_wr_en   = last_writer & {SLOTS{out_fire}};
  assign out_dst_tag = new_tags;

  AST_STALL_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    out_stall |-> (fl_pop == '0 && !out_fire)); // R9

  AST_POP_WITHIN_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
    fl_pop <= fl_avail); // R9

  AST_POP_MATCHES_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire |-> (int'(fl_pop) == $countones(in_valid & in_has_dst))); // R5

  AST_EMPTY_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    !(|in_valid) |-> (!out_fire && fl_pop == '0)); // R10

  AST_NO_WRITE_UNLESS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (|tbl_wr_en) |-> out_fire); // R8

endmodule

// File: tb/sim_rename_group.sv
module sim_rename_group;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  in_valid = '0, in_has_dst = '0;
  logic [11:0] in_src_a = '0, in_src_b = '0, in_dst = '0;
  logic [2:0]  fl_avail = '0;
  logic [19:0] fl_tags = '0;
  logic [2:0]  fl_pop;
  logic        out_fire, out_stall;
  logic [19:0] out_src_a_tag, out_src_b_tag, out_dst_tag, out_prev_tag;

  int nchk = 0;
  int nerr = 0;
  int model [8];
  int tag_ptr = 0;
  logic [31:0] rng = 32'h1234_5679;

  always #(CLK_PERIOD/2) clk = ~clk;

  rename_group u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_has_dst(in_has_dst),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst),
    .fl_avail(fl_avail), .fl_tags(fl_tags), .fl_pop(fl_pop),
    .out_fire(out_fire), .out_stall(out_stall),
    .out_src_a_tag(out_src_a_tag), .out_src_b_tag(out_src_b_tag),
    .out_dst_tag(out_dst_tag), .out_prev_tag(out_prev_tag)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int supply(input int k);
    return 8 + ((tag_ptr + k) % 24);
  endfunction

  function automatic logic [31:0] step(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  // Drive one group, predict by sequential renaming, compare, then clock it in.
  task automatic run_group(input logic [3:0] v, input logic [3:0] h, input logic [11:0] sa,
                           input logic [11:0] sb, input logic [11:0] d, input int avail,
                           input string src_req);
    int tmp [8];
    int ea [NS], eb [NS], ed [NS], ep [NS];
    bit seen [8];
    string ra, rb;
    int k;
    bit any, estall, efire;
    @(negedge clk);
    in_valid = v; in_has_dst = h; in_src_a = sa; in_src_b = sb; in_dst = d;
    fl_avail = 3'(avail);
    for (int q = 0; q < NS; q++) fl_tags[q*5 +: 5] = 5'(supply(q));
    #1;
    for (int r = 0; r < 8; r++) begin tmp[r] = model[r]; seen[r] = 0; end
    k = 0; any = 0;
    for (int i = 0; i < NS; i++) begin
      int ai, bi, di;
      ai = int'(sa[i*3 +: 3]); bi = int'(sb[i*3 +: 3]); di = int'(d[i*3 +: 3]);
      if (v[i]) begin
        any = 1;
        ra = (src_req != "") ? src_req : (seen[ai] ? "R3" : "R2");
        rb = (src_req != "") ? src_req : (seen[bi] ? "R3" : "R2");
        chk(ra, $sformatf("slot%0d src_a", i), int'(out_src_a_tag[i*5 +: 5]), tmp[ai]);
        chk(rb, $sformatf("slot%0d src_b", i), int'(out_src_b_tag[i*5 +: 5]), tmp[bi]);
        if (h[i]) begin
          ed[i] = supply(k); k++;
          ep[i] = tmp[di];
          chk("R5", $sformatf("slot%0d dst", i), int'(out_dst_tag[i*5 +: 5]), ed[i]);
          chk("R6", $sformatf("slot%0d prev", i), int'(out_prev_tag[i*5 +: 5]), ep[i]);
          tmp[di] = ed[i]; seen[di] = 1;
        end
      end
    end
    estall = any && (k > avail);
    efire  = any && !estall;
    if (!any) begin
      chk("R10", "fire", int'(out_fire), 0);
      chk("R10", "pop", int'(fl_pop), 0);
    end else if (estall) begin
      chk("R9", "stall", int'(out_stall), 1);
      chk("R9", "fire", int'(out_fire), 0);
      chk("R9", "pop", int'(fl_pop), 0);
    end else begin
      chk("R9", "stall", int'(out_stall), 0);
      chk("R5", "fire", int'(out_fire), 1);
      chk("R5", "pop", int'(fl_pop), k);
    end
    @(posedge clk);
    if (efire) begin
      for (int r = 0; r < 8; r++) model[r] = tmp[r];
      tag_ptr = (tag_ptr + k) % 24;
    end
  endtask

  // All eight registers read by valid slots without destinations.
  task automatic readout(input string req);
    run_group(4'hF, 4'h0, {3'd3, 3'd2, 3'd1, 3'd0}, {3'd7, 3'd6, 3'd5, 3'd4},
              12'h000, 0, req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nerr++;
    $display("FAIL watchdog: actual expired expected done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    for (int r = 0; r < 8; r++) model[r] = r;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    readout("R1");

    // R3/R4 chain: slot1 reads and rewrites reg1, slot3 reads reg1 and reg2
    run_group(4'hF, 4'hF, {3'd1, 3'd2, 3'd1, 3'd4}, {3'd2, 3'd1, 3'd5, 3'd6},
              {3'd1, 3'd2, 3'd1, 3'd1}, 4, "");
    readout("R7");

    // R4: each slot reads its own destination only
    run_group(4'hF, 4'hF, {3'd6, 3'd5, 3'd4, 3'd3}, {3'd6, 3'd5, 3'd4, 3'd3},
              {3'd6, 3'd5, 3'd4, 3'd3}, 4, "R4");

    // R7: all slots write reg5
    run_group(4'hF, 4'hF, {3'd5, 3'd5, 3'd5, 3'd5}, 12'h000, {3'd5, 3'd5, 3'd5, 3'd5}, 4, "");
    readout("R7");

    // R8: no-destination slots and invalid slots name registers 6 and 7
    run_group(4'hF, 4'b0101, 12'h000, 12'h000, {3'd7, 3'd0, 3'd6, 3'd2}, 4, "");
    run_group(4'b0011, 4'hF, 12'h000, 12'h000, {3'd7, 3'd6, 3'd0, 3'd3}, 4, "");
    readout("R8");

    // R9: need three, only two free; then exact fit of four
    run_group(4'hF, 4'b1110, 12'h000, 12'h000, {3'd1, 3'd2, 3'd3, 3'd4}, 2, "");
    readout("R9");
    run_group(4'hF, 4'hF, 12'h000, 12'h000, {3'd4, 3'd3, 3'd2, 3'd1}, 4, "");
    readout("R7");

    // R10: empty group
    run_group(4'h0, 4'hF, 12'h000, 12'h000, {3'd1, 3'd2, 3'd3, 3'd4}, 4, "");
    readout("R10");

    // Sweep every destination pattern with pseudo-random sources, flags and supply
    for (int n = 0; n < 4096; n++) begin
      logic [3:0] v, h;
      logic [11:0] sa, sb;
      int av;
      rng = step(rng); sa = rng[11:0]; sb = rng[23:12];
      v = rng[27:24] | ((rng[31:28] == 4'h0) ? 4'h0 : 4'h8);
      rng = step(rng); h = rng[3:0] | rng[7:4];
      av = int'(rng[15:8] % 5);
      run_group(v, h, sa, sb, 12'(n), av, "");
      if (n % 256 == 255) readout("R7");
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule